// File: doc/BRIEF.md
# Oversampled Port Edge-Interval Extractor

This block captures return telemetry from every pin of a 16-bit input port at once. A pacing tick marks each sample instant. On each tick inside a capture window, the block samples the whole port after a two-flop synchroniser. Every pin has its own edge tracker, and each tracker works on the same shared sample. A pin's tracker turns its level stream into a list of edge-to-edge distances, counted in samples. All pins therefore get a result list from every capture window, instead of one pin per window in turn.

A start strobe opens a window of 512 samples. With 20 samples per outgoing bit, a reply bit at 5/4 of the outgoing rate spans about 16 samples. A 21-bit reply then fits in roughly 336 samples, well inside the window. When the window closes, the done flag rises. Software or a downstream decoder then picks a pin with the pin selector and walks the interval list with a read index. Line decoding and checksum work happen later, outside this block.

Top module: `port_edge_extractor`

## Requirements
- R1: Each port bit passes through two flip-flops before it is sampled. The value sampled on a tick is the port value presented at least two clock edges before that tick edge.
- R2: A start strobe begins a new window, even when a window is already running. In the cycle after the strobe, done is low, every pin's count is zero and every stored entry reads zero.
- R3: A window takes exactly 512 ticks, numbered sample 0 to 511. A tick in the same cycle as start is ignored. Ticks after the window has closed change no count and no entry.
- R4: The level of pin p in a sample is bit p of that sample. The pin's reference level is its level in sample 0. An edge is any later sample whose level differs from the level of the sample before it.
- R5: The first edge of a pin only records its sample position and stores nothing. Each later edge stores its distance, in samples, from the previous edge. Entry k holds the (k+1)-th stored distance.
- R6: At most 32 distances are stored per pin. Further edges are ignored, and the count stays at 32.
- R7: Done rises in the cycle after the tick edge of sample 511, and the final counts are valid in that cycle. Done stays high until the next start. A pin without any edge reports a count of zero.
- R8: pin_sel_i selects which pin's count and list appear at the outputs. rd_idx_i selects the entry. Entries at or beyond the count read zero. All 16 pins are captured from the same window.
- R9: After reset, done is low and every count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_i | input | 16 | Raw input port levels |
| tick_i | input | 1 | Sample pacing strobe, one cycle wide |
| start_i | input | 1 | Opens a new capture window |
| pin_sel_i | input | 4 | Pin whose results are shown |
| rd_idx_i | input | 5 | Entry index into the selected pin's list |
| ivl_data_o | output | 9 | Selected distance in samples (zero past the count) |
| ivl_count_o | output | 6 | Number of stored distances for the selected pin (0 to 32) |
| done_o | output | 1 | Window complete, results valid |

## Verification
A port value must be held for two clock edges before the tick edge that samples it. The bench therefore changes the port only after a tick and raises the next tick two cycles later. Counts, entries and done all change one cycle after the tick edge of the sample that causes them. The bench reads them at the falling edge after the last tick, and at the falling edge after a start for the cleared state. The read inputs reach the outputs without a register, so the bench sets them between edges and samples 1 ns later.

// File: rtl/eix_pkg.sv
package eix_pkg;
    localparam int unsigned EIX_PINS    = 16;
    localparam int unsigned EIX_SAMPLES = 512;
    localparam int unsigned EIX_MAX_IVL = 32;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_RUN  = 2'd1,
        WIN_DONE = 2'd2
    } win_phase_e;
endpackage

// File: rtl/eix_sync.sv
module eix_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/eix_window.sv
module eix_window
    import eix_pkg::*;
#(
    parameter int unsigned NSAMP = EIX_SAMPLES,
    localparam int unsigned SW   = $clog2(NSAMP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tick_i,
    output logic          clear_o,
    output logic          samp_en_o,
    output logic [SW-1:0] samp_idx_o,
    output logic          done_o
);
    typedef struct packed {
        win_phase_e    phase;
        logic [SW-1:0] idx;
    } win_t;

    win_t st_d, st_q;
    logic take;

    always_comb begin
        st_d = st_q;
        take = (st_q.phase == WIN_RUN) && tick_i && !start_i;
        if (start_i) begin
            st_d.phase = WIN_RUN;
            st_d.idx   = '0;
        end else if (take) begin
            if (st_q.idx == SW'(NSAMP - 1)) begin
                st_d.phase = WIN_DONE;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= WIN_IDLE;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clear_o    = start_i;
    assign samp_en_o  = take;
    assign samp_idx_o = st_q.idx;
    assign done_o     = (st_q.phase == WIN_DONE);
endmodule

// File: rtl/eix_pin_tracker.sv
module eix_pin_tracker
    import eix_pkg::*;
#(
    parameter int unsigned NSAMP  = EIX_SAMPLES,
    parameter int unsigned MAXIVL = EIX_MAX_IVL,
    localparam int unsigned SW    = $clog2(NSAMP),
    localparam int unsigned CW    = $clog2(MAXIVL + 1),
    localparam int unsigned IW    = $clog2(MAXIVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          samp_en_i,
    input  logic [SW-1:0] samp_idx_i,
    input  logic          level_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [CW-1:0] count_o,
    output logic [SW-1:0] rd_data_o
);
    typedef struct packed {
        logic                     prev;
        logic                     seen;
        logic [SW-1:0]            last;
        logic [CW-1:0]            cnt;
        logic [MAXIVL-1:0][SW-1:0] mem;
    } trk_t;

    trk_t st_d, st_q;
    logic is_edge;

    always_comb begin
        st_d    = st_q;
        is_edge = samp_en_i && (samp_idx_i != '0) && (level_i != st_q.prev);
        if (clear_i) begin
            st_d.prev = 1'b0;
            st_d.seen = 1'b0;
            st_d.last = '0;
            st_d.cnt  = '0;
            st_d.mem  = '0;
        end else if (samp_en_i) begin
            if (samp_idx_i == '0) begin
                st_d.prev = level_i;
            end else if (is_edge) begin
                st_d.prev = level_i;
                st_d.seen = 1'b1;
                st_d.last = samp_idx_i;
                if (st_q.seen && (st_q.cnt < CW'(MAXIVL))) begin
                    st_d.mem[st_q.cnt[IW-1:0]] = samp_idx_i - st_q.last;
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o   = st_q.cnt;
    assign rd_data_o = st_q.mem[rd_idx_i];
endmodule

// File: rtl/port_edge_extractor.sv
module port_edge_extractor
    import eix_pkg::*;
#(
    parameter int unsigned NPINS  = EIX_PINS,
    parameter int unsigned NSAMP  = EIX_SAMPLES,
    parameter int unsigned MAXIVL = EIX_MAX_IVL,
    localparam int unsigned PW    = $clog2(NPINS),
    localparam int unsigned SW    = $clog2(NSAMP),
    localparam int unsigned CW    = $clog2(MAXIVL + 1),
    localparam int unsigned IW    = $clog2(MAXIVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] port_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic [PW-1:0]    pin_sel_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [SW-1:0]    ivl_data_o,
    output logic [CW-1:0]    ivl_count_o,
    output logic             done_o
);
    logic [NPINS-1:0] port_s;
    logic             clear;
    logic             samp_en;
    logic [SW-1:0]    samp_idx;
    logic [CW-1:0]    cnt_w  [NPINS];
    logic [SW-1:0]    data_w [NPINS];

    eix_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (port_i),
        .q_o   (port_s)
    );

    eix_window #(.NSAMP(NSAMP)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tick_i     (tick_i),
        .clear_o    (clear),
        .samp_en_o  (samp_en),
        .samp_idx_o (samp_idx),
        .done_o     (done_o)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        eix_pin_tracker #(.NSAMP(NSAMP), .MAXIVL(MAXIVL)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (clear),
            .samp_en_i  (samp_en),
            .samp_idx_i (samp_idx),
            .level_i    (port_s[p]),
            .rd_idx_i   (rd_idx_i),
            .count_o    (cnt_w[p]),
            .rd_data_o  (data_w[p])
        );
    end

    assign ivl_count_o = cnt_w[pin_sel_i];
    assign ivl_data_o  = data_w[pin_sel_i];
endmodule

// File: rtl/port_edge_extractor_checker.sv
module port_edge_extractor_checker #(
    parameter int unsigned MAXIVL = 32,
    parameter int unsigned PW     = 4,
    parameter int unsigned SW     = 9,
    parameter int unsigned CW     = 6,
    parameter int unsigned IW     = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [PW-1:0] pin_sel_i,
    input logic [IW-1:0] rd_idx_i,
    input logic [SW-1:0] ivl_data_o,
    input logic [CW-1:0] ivl_count_o,
    input logic          done_o
);
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_count_o <= CW'(MAXIVL)); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && ivl_count_o == '0)); // R2

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R7

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) ##1 $stable(pin_sel_i) |-> $stable(ivl_count_o)); // R7

    AST_NONZERO_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx_i} < ivl_count_o) |-> (ivl_data_o != '0)); // R5

    AST_ZERO_PAST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx_i} >= ivl_count_o) |-> (ivl_data_o == '0)); // R8
endmodule

bind port_edge_extractor port_edge_extractor_checker #(
    .MAXIVL (MAXIVL),
    .PW     (PW),
    .SW     (SW),
    .CW     (CW),
    .IW     (IW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pin_sel_i   (pin_sel_i),
    .rd_idx_i    (rd_idx_i),
    .ivl_data_o  (ivl_data_o),
    .ivl_count_o (ivl_count_o),
    .done_o      (done_o)
);

// File: tb/port_edge_extractor_tb.sv
`timescale 1ns/1ps
module port_edge_extractor_tb;
    localparam int NS = 512;
    localparam int NP = 16;
    localparam int MX = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_i = '0;
    logic        tick_i = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  pin_sel_i = '0;
    logic [4:0]  rd_idx_i = '0;
    logic [8:0]  ivl_data_o;
    logic [5:0]  ivl_count_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [15:0] samp [NS];
    int exp_cnt [NP];
    int exp_iv  [NP][MX];

    always #2.5 clk = ~clk;

    port_edge_extractor u_dut (
        .clk(clk), .rst_n(rst_n), .port_i(port_i), .tick_i(tick_i),
        .start_i(start_i), .pin_sel_i(pin_sel_i), .rd_idx_i(rd_idx_i),
        .ivl_data_o(ivl_data_o), .ivl_count_o(ivl_count_o), .done_o(done_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected lists per pin, from the requirement text (R4, R5, R6)
    task automatic model();
        for (int p = 0; p < NP; p++) begin
            logic prev;
            bit   seen;
            int   last;
            prev = samp[0][p];
            seen = 0;
            last = 0;
            exp_cnt[p] = 0;
            for (int k = 0; k < MX; k++) exp_iv[p][k] = 0;
            for (int i = 1; i < NS; i++) begin
                if (samp[i][p] != prev) begin
                    prev = samp[i][p];
                    if (seen && exp_cnt[p] < MX) begin
                        exp_iv[p][exp_cnt[p]] = i - last;
                        exp_cnt[p]++;
                    end
                    seen = 1;
                    last = i;
                end
            end
        end
    endtask

    task automatic gen_random(int div);
        samp[0] = 16'($urandom);
        for (int i = 1; i < NS; i++) begin
            samp[i] = samp[i-1];
            for (int p = 0; p < NP; p++)
                if ($urandom_range(div - 1) == 0) samp[i][p] = ~samp[i][p];
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // Port held two edges before each tick edge (R1)
    task automatic play(int n);
        for (int i = 0; i < n; i++) begin
            port_i = samp[i];
            @(negedge clk);
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            if (i == 300) check("R7 done low mid-window", int'(done_o), 0);
        end
    endtask

    task automatic verify(string tag);
        check({tag, " R7 done after last sample"}, int'(done_o), 1);
        for (int p = 0; p < NP; p++) begin
            pin_sel_i = 4'(p);
            rd_idx_i = '0;
            #1;
            check({tag, " R8 count"}, int'(ivl_count_o), exp_cnt[p]);
            for (int k = 0; k < MX; k++) begin
                rd_idx_i = 5'(k);
                #1;
                check({tag, " R5 entry"}, int'(ivl_data_o), exp_iv[p][k]);
            end
        end
    endtask

    task automatic full_run(string tag);
        model();
        pulse_start();
        play(NS);
        verify(tag);
    endtask

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        check("R9 done after reset", int'(done_o), 0);
        check("R9 count after reset", int'(ivl_count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: constant port gives zero counts (R7)
        for (int i = 0; i < NS; i++) samp[i] = 16'h0001;
        full_run("const");

        // Directed corners (R4, R5, R6)
        for (int i = 0; i < NS; i++) begin
            samp[i] = '0;
            samp[i][3]  = (i >= 100);                 // single edge: count 0
            samp[i][5]  = (i >= 10 && i < 30) || (i >= 31); // R5 intervals 20,1
            samp[i][15] = i[0];                       // R6 saturation, all 1
            samp[i][8]  = (i == 511);                 // edge on last sample
            samp[i][9]  = (i >= 1 && i < 511);        // R5 interval 510
        end
        full_run("directed");

        // Random patterns
        gen_random(16); full_run("rand16");
        gen_random(3);  full_run("rand3");
        gen_random(40); full_run("rand40");

        // R3: ticks after the window change nothing
        for (int j = 0; j < 20; j++) begin
            @(negedge clk); port_i = 16'($urandom);
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
        verify("R3 idle ticks");

        // R2: start clears, and restarts a running window
        pulse_start();
        pin_sel_i = 4'd15; rd_idx_i = '0; #1;
        check("R2 done cleared", int'(done_o), 0);
        check("R2 count cleared", int'(ivl_count_o), 0);
        check("R2 entry cleared", int'(ivl_data_o), 0);
        gen_random(4);
        play(150);
        gen_random(12);
        full_run("R2 restart");

        // R3: tick in same cycle as start is ignored
        gen_random(10);
        model();
        @(negedge clk); port_i = 16'hFFFF ^ samp[0];
        @(negedge clk); @(negedge clk);
        start_i = 1'b1; tick_i = 1'b1;
        @(negedge clk); start_i = 1'b0; tick_i = 1'b0;
        play(NS);
        verify("R3 start+tick");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule